// File: doc/BRIEF.md
# Register Field Read-Modify-Write Engine

This block changes a single bit field inside one 32-bit register and leaves the rest of the word alone. A request carries a packed 32-bit descriptor and a 32-bit value. The descriptor supplies a 16-bit register address, a field width and a bit offset. The engine works out the bus address, builds the mask of bits to keep and cuts the value down to the field width. It then reads the register, merges the value in at the offset and writes the new word back over a request/acknowledge master port.

Only one transaction is open at a time. The request port stays not-ready from the cycle a request is accepted until the done pulse that closes it. Some descriptors describe a field that runs past bit 31. Such a request finishes at once with an error, and no bus access is made for it.

Top module: `fld_rmw_engine`

## Requirements
- R1: The descriptor is decoded as register address = bits [31:16], field width = bits [15:8] and bit offset = bits [7:0]. Every bus access of a request goes to BASE_ADDR + register address, where the register address is zero-extended to the bus address width.
- R2: Only the bits from offset up to offset + width - 1 take new contents. All other bits of the written word equal the word that was read.
- R3: The value is truncated to the field width before it is shifted. Value bits at or above the width never reach the written word.
- R4: A width of 32 with offset 0 replaces the whole word with the value.
- R5: When offset + width is greater than 32, the request ends with done and error both high in the cycle after acceptance. No bus read or write is made for it.
- R6: A valid request makes one read (busWe = 0) followed by one write (busWe = 1). The write is raised only after the read acknowledge has been taken.
- R7: reqReady is high when idle. It is low from the cycle after a request is accepted up to and including the done cycle, and high again in the cycle after done. A request presented while not ready is not taken.
- R8: done is a single-cycle pulse, given exactly once per accepted request. error is only high together with done.
- R9: After reset, reqReady is high and busReq, done and error are low.
- R10: While busReq is high and busAck has not been seen, busReq, busWe, busAddr and busWdata hold steady.
- R11: A width of 0 with offset + width at most 32 is valid. It still makes the read and the write, and it writes back the unchanged word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented |
| reqReady | output | 1 | Engine idle; the request is taken this cycle when valid |
| reqDesc | input | 32 | Packed field descriptor (address, width, offset) |
| reqValue | input | 32 | Value to place in the field |
| busReq | output | 1 | Bus access pending; held until busAck |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | BUS_AW | Target register address |
| busWdata | output | 32 | Merged word for the write |
| busRdata | input | 32 | Read data, valid with busAck on a read |
| busAck | input | 1 | Completes the pending access |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Field out of range; valid with done |

## Verification
The bench builds the engine with a 32-bit bus address and BASE_ADDR = 32'hF0F0_0000. Because the base sits in the upper bits, a wrong decode or a dropped base lands outside the slave's small register window, and the slave counts that as a bad access. The slave's acknowledge latency steps through 0 to 3 cycles, so the hold of a pending access and the read-before-write order are both exercised with back-to-back and delayed answers. The descriptors cover a full-word field, a single top bit, a field ending exactly at bit 31, width 0, and widths and offsets that overflow.

// File: rtl/fld_rmw_pkg.sv
package fld_rmw_pkg;

  localparam int WORD_W  = 32;
  localparam int ADDR16W = 16;
  localparam int FLD_W   = 8;

  typedef struct packed {
    logic [ADDR16W-1:0] regAddr;
    logic [FLD_W-1:0]   width;
    logic [FLD_W-1:0]   offset;
  } fieldDesc_t;

  typedef struct packed {
    logic loadReq;
    logic captureRead;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN = 2'd3
  } rmwState_t;

  // Ones in the low 'w' bits; saturates at a full word without overshifting.
  function automatic logic [WORD_W-1:0] lowOnes(input logic [FLD_W-1:0] w);
    logic [WORD_W:0] wide;
    if (w >= FLD_W'(WORD_W)) begin
      lowOnes = '1;
    end else begin
      wide = ({{WORD_W{1'b0}}, 1'b1} << w) - 1'b1;
      lowOnes = wide[WORD_W-1:0];
    end
  endfunction

  function automatic logic fieldOutOfRange(input fieldDesc_t d);
    logic [FLD_W:0] span;
    span = {1'b0, d.width} + {1'b0, d.offset};
    fieldOutOfRange = (span > (FLD_W+1)'(WORD_W));
  endfunction

endpackage

// File: rtl/fld_rmw_dp.sv
module fld_rmw_dp
  import fld_rmw_pkg::*;
#(
  parameter int BUS_AW = 32,
  parameter logic [BUS_AW-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] reqDesc,
  input  logic [WORD_W-1:0] reqValue,
  input  logic [WORD_W-1:0] busRdata,
  output logic              reqBad,
  output logic [BUS_AW-1:0] busAddr,
  output logic [WORD_W-1:0] mergedWord
);

  fieldDesc_t        descR;
  logic [WORD_W-1:0] valueR;
  logic [WORD_W-1:0] mergedR;
  logic [WORD_W-1:0] fieldMask;
  logic [WORD_W-1:0] placedVal;
  logic [WORD_W-1:0] mergeNext;

  assign reqBad = fieldOutOfRange(fieldDesc_t'(reqDesc));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descR  <= '0;
      valueR <= '0;
    end else if (strobe.loadReq) begin
      descR  <= fieldDesc_t'(reqDesc);
      valueR <= reqValue;
    end
  end

  always_comb begin
    fieldMask = lowOnes(descR.width) << descR.offset;
    placedVal = (valueR & lowOnes(descR.width)) << descR.offset;
    mergeNext = (busRdata & ~fieldMask) | placedVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mergedR <= '0;
    end else if (strobe.captureRead) begin
      mergedR <= mergeNext;
    end
  end

  assign busAddr    = BASE_ADDR + {{(BUS_AW-ADDR16W){1'b0}}, descR.regAddr};
  assign mergedWord = mergedR;

  // R4
  full_word_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureRead && descR.width == FLD_W'(WORD_W) && descR.offset == '0)
      |=> (mergedR == valueR));

endmodule

// File: rtl/fld_rmw_ctrl.sv
module fld_rmw_ctrl
  import fld_rmw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqBad,
  input  logic      busAck,
  output logic      reqReady,
  output logic      busReq,
  output logic      busWe,
  output logic      done,
  output logic      error,
  output dpStrobe_t strobe
);

  rmwState_t state;
  logic      errR;
  logic      accept;

  assign accept = reqValid && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      errR  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          errR  <= reqBad;
          state <= reqBad ? ST_FIN : ST_READ;
        end
        ST_READ:  if (busAck) state <= ST_WRITE;
        ST_WRITE: if (busAck) state <= ST_FIN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady           = (state == ST_IDLE);
    busReq             = (state == ST_READ) || (state == ST_WRITE);
    busWe              = (state == ST_WRITE);
    done               = (state == ST_FIN);
    error              = (state == ST_FIN) && errR;
    strobe.loadReq     = accept;
    strobe.captureRead = (state == ST_READ) && busAck;
  end

  // R6
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe && !$past(busReq && busWe)) |-> $past(busReq && !busWe && busAck));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));

  // R8
  error_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  // R5
  error_no_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && error) |-> ($past(reqReady) && !$past(busReq)));

endmodule

// File: rtl/fld_rmw_engine.sv
module fld_rmw_engine
  import fld_rmw_pkg::*;
#(
  parameter int BUS_AW = 32,
  parameter logic [BUS_AW-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [31:0]       reqDesc,
  input  logic [31:0]       reqValue,
  output logic              busReq,
  output logic              busWe,
  output logic [BUS_AW-1:0] busAddr,
  output logic [31:0]       busWdata,
  input  logic [31:0]       busRdata,
  input  logic              busAck,
  output logic              done,
  output logic              error
);

  dpStrobe_t strobe;
  logic      reqBad;

  fld_rmw_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqBad   (reqBad),
    .busAck   (busAck),
    .reqReady (reqReady),
    .busReq   (busReq),
    .busWe    (busWe),
    .done     (done),
    .error    (error),
    .strobe   (strobe)
  );

  fld_rmw_dp #(
    .BUS_AW    (BUS_AW),
    .BASE_ADDR (BASE_ADDR)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqDesc    (reqDesc),
    .reqValue   (reqValue),
    .busRdata   (busRdata),
    .reqBad     (reqBad),
    .busAddr    (busAddr),
    .mergedWord (busWdata)
  );

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busWe) && $stable(busAddr) && $stable(busWdata)));

endmodule

// File: tb/test_fld_rmw_engine.sv
module test_fld_rmw_engine;

  localparam int          AW    = 32;
  localparam logic [31:0] BASE  = 32'hF0F0_0000;
  localparam int          DEPTH = 16;

  typedef struct {
    bit          err;
    int          idx;
    logic [31:0] expWord;
    int          expReads;
    int          expWrites;
  } item_t;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid;
  logic          reqReady;
  logic [31:0]   reqDesc;
  logic [31:0]   reqValue;
  logic          busReq;
  logic          busWe;
  logic [AW-1:0] busAddr;
  logic [31:0]   busWdata;
  logic [31:0]   busRdata;
  logic          busAck;
  logic          done;
  logic          error;

  int checks = 0;
  int fails  = 0;
  int reads  = 0;
  int writes = 0;
  int badAddr = 0;
  int expR   = 0;
  int expW   = 0;
  bit finished = 1'b0;

  logic [31:0] slaveMem  [DEPTH];
  logic [31:0] shadowMem [DEPTH];
  item_t       sbQueue[$];

  always #2 clk = ~clk;

  fld_rmw_engine #(.BUS_AW(AW), .BASE_ADDR(BASE)) i_fld_rmw_engine (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqDesc(reqDesc), .reqValue(reqValue), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busAck(busAck), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] initWord(input int i);
    initWord = 32'h1357_9BDF ^ (32'(i) * 32'h0903_0507);
  endfunction

  // Bit-by-bit reference merge
  function automatic logic [31:0] refMerge(input logic [31:0] old, input int w,
                                           input int off, input logic [31:0] val);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 32; b++) begin
      if (b >= off && b < off + w) r[b] = val[b - off];
    end
    refMerge = r;
  endfunction

  // Bus slave: latency cycles through 0..3
  initial begin
    int cnt;
    int idx;
    int lat;
    cnt = 0;
    busAck = 1'b0;
    busRdata = '0;
    for (int i = 0; i < DEPTH; i++) slaveMem[i] = initWord(i);
    forever begin
      @(negedge clk);
      lat = (reads + writes) % 4;
      if (busAck) begin
        busAck = 1'b0;
      end else if (rstN === 1'b1 && busReq === 1'b1) begin
        if (cnt >= lat) begin
          idx = int'(busAddr - BASE);
          if (busAddr < BASE || idx >= DEPTH) begin
            badAddr++;
          end else if (busWe) begin
            slaveMem[idx] = busWdata;
            writes++;
          end else begin
            busRdata = slaveMem[idx];
            reads++;
          end
          busAck = 1'b1;
          cnt = 0;
        end else begin
          cnt++;
        end
      end
    end
  end

  task automatic drive(input int regAddr, input int w, input int off, input logic [31:0] val);
    item_t it;
    it.err = (w + off > 32);
    it.idx = regAddr;
    if (!it.err) begin
      shadowMem[regAddr] = refMerge(shadowMem[regAddr], w, off, val);
      expR++;
      expW++;
    end
    it.expWord   = shadowMem[regAddr];
    it.expReads  = expR;
    it.expWrites = expW;
    @(negedge clk);
    reqDesc  = {16'(regAddr), 8'(w), 8'(off)};
    reqValue = val;
    reqValid = 1'b1;
    while (reqReady !== 1'b1) @(negedge clk);
    sbQueue.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (done === 1'b1) begin
        if (sbQueue.size() == 0) begin
          chk(1'b0, "R8", "unexpected done", 32'd1, 32'd0);
        end else begin
          it = sbQueue.pop_front();
          chk(error === it.err, "R5", "error flag", 32'(error), 32'(it.err));
          chk(reqReady === 1'b0, "R7", "ready during done", 32'(reqReady), 32'd0);
          chk(slaveMem[it.idx] === it.expWord, "R2", "register word",
              slaveMem[it.idx], it.expWord);
          chk(reads == it.expReads, "R6", "read count", 32'(reads), 32'(it.expReads));
          chk(writes == it.expWrites, "R6", "write count", 32'(writes), 32'(it.expWrites));
          @(negedge clk);
          chk(done === 1'b0, "R8", "done width", 32'(done), 32'd0);
          chk(reqReady === 1'b1, "R7", "ready after done", 32'(reqReady), 32'd1);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadowMem[i] = initWord(i);
    rstN = 1'b0;
    reqValid = 1'b0;
    reqDesc = '0;
    reqValue = '0;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(reqReady === 1'b1, "R9", "ready in reset", 32'(reqReady), 32'd1);
    chk(busReq === 1'b0, "R9", "busReq in reset", 32'(busReq), 32'd0);
    chk(done === 1'b0 && error === 1'b0, "R9", "done/error in reset",
        32'({done, error}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady === 1'b1 && busReq === 1'b0, "R9", "idle after reset",
        32'({reqReady, busReq}), 32'h2);

    drive(3, 8, 4, 32'h0000_0ABC);    // R3 truncation, R1 decode
    drive(7, 32, 0, 32'hDEAD_BEEF);   // R4 full word
    drive(1, 1, 31, 32'hFFFF_FFFE);   // R3 value bit0 = 0 into bit 31
    drive(1, 1, 31, 32'hFFFF_FFFF);   // R2 top bit set
    drive(2, 0, 10, 32'h0000_0123);   // R11 width zero
    drive(9, 20, 13, 32'h000F_FFFF);  // R5 overflow by one
    drive(4, 16, 16, 32'h1234_5678);  // R2 field ending at bit 31
    drive(0, 255, 0, 32'h5555_5555);  // R5 huge width
    drive(15, 5, 0, 32'h0000_003F);   // R3 truncation at low end
    drive(12, 12, 20, 32'h0000_0A5A); // R1 upper register
    drive(5, 0, 32, 32'hFFFF_FFFF);   // R11 width zero at offset 32
    drive(6, 4, 40, 32'h0000_0003);   // R5 offset past word

    while (sbQueue.size() != 0 || reqReady !== 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(badAddr == 0, "R1", "accesses outside base window", 32'(badAddr), 32'd0);
    chk(sbQueue.size() == 0, "R8", "pending items", 32'(sbQueue.size()), 32'd0);
    for (int i = 0; i < DEPTH; i++) begin
      chk(slaveMem[i] === shadowMem[i], "R2", "final register image",
          slaveMem[i], shadowMem[i]);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule